// File: doc/BRIEF.md
# Second-Operand Fetch and Shifter

This combinational unit produces the second ALU operand and the shifter carry-out for a 32-bit processor with sixteen registers. It takes the decoded operand fields of an instruction, the values on two register-file read ports, the address of the current instruction, the status word and the carry flag. From these it builds the operand in one of three ways. It can rotate an 8-bit immediate. It can shift a register by an amount given in the instruction. It can shift a register by an amount held in a second register.

Register 15 is the program counter, and the unit substitutes its own value when an instruction names it. How far the counter looks ahead depends on which port reads it and on how the shift amount is given. When it is read as the shifted value, the status bits are merged in. When it is read as the shift amount, they are cleared. A mode input turns off register-specified amounts, so that one unit can serve instruction classes that only allow an amount in the instruction. The shifter carry replaces the incoming carry flag only when the instruction sets flags.

Top module: `opnd_shifter`

## Requirements
- R1: In immediate form (`isImmediate`=1) the operand is the zero-extended `immByte` rotated right by twice `rotField`.
- R2: In immediate form with `setFlags`=1 and `rotField`≠0, `carryOut` equals bit 31 of the operand. With `rotField`=0 it equals `carryIn`.
- R3: Shift codes are 00 logical left, 01 logical right, 10 arithmetic right and 11 rotate right. For amounts 1 to 31 the result is the shifted register. The carry is the last bit shifted out.
- R4: A shift amount of 0 leaves the operand equal to the source register and the carry equal to `carryIn`.
- R5: Logical left by 32 gives 0 with carry = bit 0. Logical right by 32 gives 0 with carry = bit 31. Logical shifts above 32 give 0 with carry 0. Arithmetic right by 32 or more fills with bit 31, and the carry is bit 31. Rotate right by a non-zero multiple of 32 leaves the value unchanged with carry = bit 31. Other rotate amounts use the amount modulo 32.
- R6: A register-specified amount (`amtFromReg`=1, `regShiftAllowed`=1) uses only bits 7:0 of `rsData`.
- R7: When `rsIdx`=15 supplies the amount, the amount is bits 7:0 of ((`pcValue`+8) & 0x03FFFFFC). The status bits are zero.
- R8: When `rmIdx`=15 and the amount comes from the instruction, the shifted value is ((`pcValue`+8) & 0x03FFFFFC) | (`statusWord` & 0xFC000003).
- R9: When `rmIdx`=15 and the amount comes from a register, the shifted value is ((`pcValue`+12) & 0x03FFFFFC) | (`statusWord` & 0xFC000003).
- R10: With `regShiftAllowed`=0, the amount is always `shiftImm`, whatever `amtFromReg` says. Register 15 in the shifted position then reads as the +8 value.
- R11: With `setFlags`=0, `carryOut` always equals `carryIn`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| isImmediate | input | 1 | Select the rotated-immediate form |
| regShiftAllowed | input | 1 | Mode: permit register-specified shift amounts |
| amtFromReg | input | 1 | Instruction asks for a register-specified amount |
| setFlags | input | 1 | Instruction updates flags; the shifter carry is used |
| shiftKind | input | 2 | Shift type code |
| shiftImm | input | 5 | Shift amount held in the instruction |
| rotField | input | 4 | Immediate rotate field |
| immByte | input | 8 | Immediate value |
| rmIdx | input | 4 | Index of the shifted register |
| rsIdx | input | 4 | Index of the shift-amount register |
| rmData | input | 32 | Read-port value for `rmIdx` |
| rsData | input | 32 | Read-port value for `rsIdx` |
| pcValue | input | 32 | Address of the current instruction |
| statusWord | input | 32 | Status word; only bits outside the PC mask are used |
| carryIn | input | 1 | Current carry flag |
| operand | output | 32 | Second ALU operand |
| carryOut | output | 1 | Shifter carry-out |

## Verification
The assertions check four relations on every input combination. The carry is held when flags are not set. A zero rotate passes the immediate through. A non-zero rotate copies the top operand bit into the carry when flags are set. An instruction-held amount of zero passes the register through. Only the bench's sweeps can show the full behaviour of each shift code at every amount boundary (0, 1, 31, 32, above 32, and amounts above 255 that wrap through the low byte). The same holds for the three program-counter substitutions and their offsets and status merging, and for the effect of the mode input. There the expected values come from an arithmetic reference.

// File: rtl/opnd_pkg.sv
package opnd_pkg;
  localparam int DATA_W = 32;
  localparam int IDX_W = 4;
  localparam int AMT_W = 8;
  localparam logic [IDX_W-1:0] PC_IDX = 4'd15;

  typedef enum logic [1:0] {
    SH_LSL = 2'b00,
    SH_LSR = 2'b01,
    SH_ASR = 2'b10,
    SH_ROR = 2'b11
  } shKind_e;

  typedef struct packed {
    logic immForm;
    logic regAmount;
    logic rmIsPc;
    logic rsIsPc;
    logic rmAhead12;
    logic useShiftCarry;
  } opStrobe_t;
endpackage

// File: rtl/opnd_ctrl.sv
module opnd_ctrl
  import opnd_pkg::*;
(
  input  logic             isImmediate,
  input  logic             regShiftAllowed,
  input  logic             amtFromReg,
  input  logic             setFlags,
  input  logic [IDX_W-1:0] rmIdx,
  input  logic [IDX_W-1:0] rsIdx,
  output opStrobe_t        strobe
);
  logic regAmt;

  always_comb begin
    regAmt = !isImmediate && amtFromReg && regShiftAllowed;
    strobe.immForm = isImmediate;
    strobe.regAmount = regAmt;
    strobe.rmIsPc = !isImmediate && (rmIdx == PC_IDX);
    strobe.rsIsPc = regAmt && (rsIdx == PC_IDX);
    strobe.rmAhead12 = regAmt;
    strobe.useShiftCarry = setFlags;
  end
endmodule

// File: rtl/opnd_datapath.sv
module opnd_datapath
  import opnd_pkg::*;
#(
  parameter logic [DATA_W-1:0] PC_MASK = 32'h03FF_FFFC,
  parameter int AHEAD_NEAR = 8,
  parameter int AHEAD_FAR = 12
) (
  input  opStrobe_t         strobe,
  input  logic [1:0]        shiftKind,
  input  logic [4:0]        shiftImm,
  input  logic [3:0]        rotField,
  input  logic [7:0]        immByte,
  input  logic [DATA_W-1:0] rmData,
  input  logic [DATA_W-1:0] rsData,
  input  logic [DATA_W-1:0] pcValue,
  input  logic [DATA_W-1:0] statusWord,
  input  logic              carryIn,
  output logic [DATA_W-1:0] operand,
  output logic              carryOut
);
  localparam int SH_W = $clog2(DATA_W);

  logic [DATA_W-1:0] pcNear, pcFar, statusPart, rmVal, rsVal;
  logic [AMT_W-1:0]  amount;
  logic [DATA_W-1:0] shRes, immVal, immRot;
  logic              shCarry, immCarry;
  logic [SH_W-1:0]   rotN, immRotN;

  always_comb begin
    pcNear = (pcValue + DATA_W'(AHEAD_NEAR)) & PC_MASK;
    pcFar = (pcValue + DATA_W'(AHEAD_FAR)) & PC_MASK;
    statusPart = statusWord & ~PC_MASK;
    rsVal = strobe.rsIsPc ? pcNear : rsData;
    if (strobe.rmIsPc) rmVal = (strobe.rmAhead12 ? pcFar : pcNear) | statusPart;
    else rmVal = rmData;
    amount = strobe.regAmount ? rsVal[AMT_W-1:0] : AMT_W'(shiftImm);
  end

  // register shifter
  always_comb begin
    shRes = rmVal;
    shCarry = carryIn;
    rotN = amount[SH_W-1:0];
    if (amount != '0) begin
      unique case (shKind_e'(shiftKind))
        SH_LSL: begin
          if (amount < AMT_W'(DATA_W)) begin
            shRes = rmVal << amount;
            shCarry = rmVal[DATA_W - int'(amount)];
          end else begin
            shRes = '0;
            shCarry = (amount == AMT_W'(DATA_W)) ? rmVal[0] : 1'b0;
          end
        end
        SH_LSR: begin
          if (amount < AMT_W'(DATA_W)) begin
            shRes = rmVal >> amount;
            shCarry = rmVal[int'(amount) - 1];
          end else begin
            shRes = '0;
            shCarry = (amount == AMT_W'(DATA_W)) ? rmVal[DATA_W-1] : 1'b0;
          end
        end
        SH_ASR: begin
          if (amount < AMT_W'(DATA_W)) begin
            shRes = DATA_W'($signed(rmVal) >>> amount);
            shCarry = rmVal[int'(amount) - 1];
          end else begin
            shRes = {DATA_W{rmVal[DATA_W-1]}};
            shCarry = rmVal[DATA_W-1];
          end
        end
        SH_ROR: begin
          if (rotN == '0) begin
            shRes = rmVal;
            shCarry = rmVal[DATA_W-1];
          end else begin
            shRes = (rmVal >> rotN) | (rmVal << (SH_W'(DATA_W - int'(rotN))));
            shCarry = rmVal[int'(rotN) - 1];
          end
        end
        default: ;
      endcase
    end
  end

  // immediate rotator
  always_comb begin
    immVal = DATA_W'(immByte);
    immRotN = SH_W'({rotField, 1'b0});
    if (rotField == '0) begin
      immRot = immVal;
      immCarry = carryIn;
    end else begin
      immRot = (immVal >> immRotN) | (immVal << (SH_W'(DATA_W - int'(immRotN))));
      immCarry = immRot[DATA_W-1];
    end
  end

  always_comb begin
    operand = strobe.immForm ? immRot : shRes;
    if (!strobe.useShiftCarry) carryOut = carryIn;
    else carryOut = strobe.immForm ? immCarry : shCarry;
  end
endmodule

// File: rtl/opnd_shifter.sv
module opnd_shifter
  import opnd_pkg::*;
(
  input  logic        isImmediate,
  input  logic        regShiftAllowed,
  input  logic        amtFromReg,
  input  logic        setFlags,
  input  logic [1:0]  shiftKind,
  input  logic [4:0]  shiftImm,
  input  logic [3:0]  rotField,
  input  logic [7:0]  immByte,
  input  logic [3:0]  rmIdx,
  input  logic [3:0]  rsIdx,
  input  logic [31:0] rmData,
  input  logic [31:0] rsData,
  input  logic [31:0] pcValue,
  input  logic [31:0] statusWord,
  input  logic        carryIn,
  output logic [31:0] operand,
  output logic        carryOut
);
  opStrobe_t strobe;

  opnd_ctrl ctrl_i (
    .isImmediate(isImmediate), .regShiftAllowed(regShiftAllowed),
    .amtFromReg(amtFromReg), .setFlags(setFlags),
    .rmIdx(rmIdx), .rsIdx(rsIdx), .strobe(strobe)
  );

  opnd_datapath dp_i (
    .strobe(strobe), .shiftKind(shiftKind), .shiftImm(shiftImm),
    .rotField(rotField), .immByte(immByte), .rmData(rmData), .rsData(rsData),
    .pcValue(pcValue), .statusWord(statusWord), .carryIn(carryIn),
    .operand(operand), .carryOut(carryOut)
  );
endmodule

// File: rtl/opnd_shifter_chk.sv
module opnd_shifter_chk (
  input logic        isImmediate,
  input logic        regShiftAllowed,
  input logic        amtFromReg,
  input logic        setFlags,
  input logic [4:0]  shiftImm,
  input logic [3:0]  rotField,
  input logic [7:0]  immByte,
  input logic [3:0]  rmIdx,
  input logic [31:0] rmData,
  input logic        carryIn,
  input logic [31:0] operand,
  input logic        carryOut
);
  always_comb begin
    // R11
    a_r11_carry_hold: assert (setFlags || (carryOut == carryIn));
    // R1
    if (isImmediate && rotField == 4'd0)
      a_r1_zero_rotate: assert (operand == {24'd0, immByte} && carryOut == carryIn);
    // R2
    if (isImmediate && setFlags && rotField != 4'd0)
      a_r2_imm_carry: assert (carryOut == operand[31]);
    // R4
    if (!isImmediate && !(amtFromReg && regShiftAllowed) && shiftImm == 5'd0 && rmIdx != 4'd15)
      a_r4_zero_pass: assert (operand == rmData && carryOut == carryIn);
  end
endmodule

bind opnd_shifter opnd_shifter_chk chk_i (
  .isImmediate(isImmediate), .regShiftAllowed(regShiftAllowed),
  .amtFromReg(amtFromReg), .setFlags(setFlags), .shiftImm(shiftImm),
  .rotField(rotField), .immByte(immByte), .rmIdx(rmIdx), .rmData(rmData),
  .carryIn(carryIn), .operand(operand), .carryOut(carryOut)
);

// File: tb/opnd_shifter_tb_top.sv
`timescale 1ns/1ps
module opnd_shifter_tb_top;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  always #4 clk = ~clk;

  logic        isImmediate, regShiftAllowed, amtFromReg, setFlags, carryIn;
  logic [1:0]  shiftKind;
  logic [4:0]  shiftImm;
  logic [3:0]  rotField, rmIdx, rsIdx;
  logic [7:0]  immByte;
  logic [31:0] rmData, rsData, pcValue, statusWord, operand;
  logic        carryOut;

  int testsRun = 0;
  int testsFailed = 0;
  bit finished = 1'b0;

  localparam logic [31:0] MASK = 32'h03FF_FFFC;

  opnd_shifter dut_i (.*);

  function automatic logic [32:0] refShift(input logic [1:0] k, input logic [31:0] v,
                                           input logic [7:0] a, input logic c);
    logic [63:0] w;
    int n;
    if (a == 8'd0) return {c, v};
    case (k)
      2'd0: begin w = {32'd0, v} << a; return {w[32], w[31:0]}; end
      2'd1: begin w = {v, 32'd0} >> a; return {w[31], w[63:32]}; end
      2'd2: begin
        w = $signed({v, 32'd0}) >>> ((a > 8'd63) ? 8'd63 : a);
        return {w[31], w[63:32]};
      end
      default: begin
        n = int'(a) % 32;
        if (n == 0) return {v[31], v};
        return {v[n-1], (v >> n) | (v << (32 - n))};
      end
    endcase
  endfunction

  task automatic check(input string tag, input logic [31:0] gotOp, input logic [31:0] expOp,
                       input logic gotC, input logic expC);
    testsRun++;
    if (gotOp !== expOp || gotC !== expC) begin
      testsFailed++;
      $display("FAIL %s: operand=%h carry=%b expected operand=%h carry=%b",
               tag, gotOp, gotC, expOp, expC);
    end
  endtask

  task automatic idle();
    isImmediate = 0; regShiftAllowed = 1; amtFromReg = 0; setFlags = 0; carryIn = 0;
    shiftKind = 0; shiftImm = 0; rotField = 0; rmIdx = 4'd2; rsIdx = 4'd3;
    immByte = 0; rmData = 0; rsData = 0; pcValue = 0; statusWord = 0;
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    if (!finished) begin
      testsRun++; testsFailed++;
      $display("FAIL watchdog: run did not complete, expected completion");
      $display("  [TB] %0d tests run, %0d failed", testsRun, testsFailed);
      $finish;
    end
  end

  initial begin : stim
    logic [31:0] pats [4];
    logic [7:0]  amts [12];
    logic [32:0] e;
    logic [31:0] exp32;
    string tag;
    pats = '{32'h8000_0001, 32'h7FFF_FFFE, 32'hA5C3_0F96, 32'h0000_0000};
    amts = '{8'd0, 8'd1, 8'd2, 8'd15, 8'd31, 8'd32, 8'd33, 8'd40, 8'd64, 8'd255, 8'd96, 8'd31};
    idle();
    repeat (3) @(posedge clk);
    rstN = 1'b1;
    @(negedge clk);
    #1 check("R4 reset-idle", operand, 32'd0, carryOut, 1'b0);

    // R1 R2 immediate sweep
    for (int r = 0; r < 16; r++) begin
      for (int b = 0; b < 256; b += 37) begin
        for (int s = 0; s < 2; s++) begin
          for (int c = 0; c < 2; c++) begin
            idle(); isImmediate = 1; rotField = 4'(r); immByte = 8'(b);
            setFlags = s[0]; carryIn = c[0];
            exp32 = (r == 0) ? 32'(b) : ((32'(b) >> (2*r)) | (32'(b) << (32 - 2*r)));
            #2 check(s != 0 ? "R2" : "R1", operand, exp32, carryOut,
                     (s != 0 && r != 0) ? exp32[31] : c[0]);
          end
        end
      end
    end

    // R3 R4 R5 R11 register shift sweeps, both amount sources
    for (int k = 0; k < 4; k++) begin
      for (int ai = 0; ai < 12; ai++) begin
        for (int p = 0; p < 4; p++) begin
          for (int m = 0; m < 2; m++) begin
            for (int sc = 0; sc < 4; sc++) begin
              if (m == 0 && amts[ai] > 8'd31) continue;
              idle(); shiftKind = 2'(k); rmData = pats[p];
              setFlags = sc[1]; carryIn = sc[0];
              if (m == 0) shiftImm = 5'(amts[ai]);
              else begin amtFromReg = 1; rsData = {24'h5A5A5A, amts[ai]}; end
              e = refShift(2'(k), pats[p], amts[ai], sc[0]);
              if (sc[1] == 0) tag = "R11";
              else if (amts[ai] == 0) tag = "R4";
              else if (amts[ai] >= 32) tag = "R5";
              else tag = "R3";
              #2 check(tag, operand, e[31:0], carryOut, sc[1] ? e[32] : sc[0]);
            end
          end
        end
      end
    end

    // R6: only low byte of rs counts (0x104 -> 4)
    idle(); amtFromReg = 1; setFlags = 1; rsData = 32'h0000_0104; rmData = 32'h0000_00F1;
    #2 check("R6 low byte", operand, 32'h0000_0F10, carryOut, 1'b0);
    idle(); amtFromReg = 1; setFlags = 1; carryIn = 1; shiftKind = 2'd1;
    rsData = 32'hFFFF_FF00; rmData = 32'h1234_5678;
    #2 check("R6 byte zero", operand, 32'h1234_5678, carryOut, 1'b1);

    // R7: rs = 15 gives (pc+8)&mask, status excluded
    idle(); amtFromReg = 1; rsIdx = 4'd15; rmData = 32'h0001_0000; shiftKind = 2'd1;
    pcValue = 32'h1000_0004; statusWord = 32'hFFFF_FFFF; rsData = 32'd1;
    #2 check("R7 rs pc", operand, 32'h0001_0000 >> 12, carryOut, 1'b0);

    // R8: rm = 15, immediate amount
    for (int q = 0; q < 3; q++) begin
      idle(); rmIdx = 4'd15; rmData = 32'hDEAD_BEEF;
      pcValue = 32'h0000_1000 + 32'(q) * 32'h0123_4564 + 32'hFC00_0000 * 32'(q);
      statusWord = (q == 0) ? 32'hFFFF_FFFF : 32'h5400_0002 * 32'(q);
      exp32 = ((pcValue + 32'd8) & MASK) | (statusWord & ~MASK);
      #2 check("R8 rm pc+8", operand, exp32, carryOut, 1'b0);
    end

    // R9: rm = 15, register amount (zero)
    for (int q = 0; q < 3; q++) begin
      idle(); rmIdx = 4'd15; amtFromReg = 1; rsData = 32'h0000_0100;
      pcValue = 32'h03FF_FFF8 - 32'(q) * 32'h0010_0000; statusWord = 32'hA800_0001 + 32'(q);
      exp32 = ((pcValue + 32'd12) & MASK) | (statusWord & ~MASK);
      #2 check("R9 rm pc+12", operand, exp32, carryOut, 1'b0);
    end

    // R10: mode input blocks register amount
    idle(); regShiftAllowed = 0; amtFromReg = 1; shiftImm = 5'd4; rsData = 32'd9;
    rmData = 32'h0000_0011; setFlags = 1;
    #2 check("R10 imm amount", operand, 32'h0000_0110, carryOut, 1'b0);
    idle(); regShiftAllowed = 0; amtFromReg = 1; rmIdx = 4'd15; rsIdx = 4'd15;
    pcValue = 32'h0000_2000; statusWord = 32'h8000_0003;
    #2 check("R10 pc+8", operand, 32'h8000_2008 | 32'h3, carryOut, 1'b0);

    finished = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", testsRun, testsFailed);
    $finish;
  end
endmodule